// File: doc/BRIEF.md
# Message Bus Arbiter with Aging

This block shares one single-cycle message bus among a parameterised set of requesters, for example a processor interface, counting semaphores, queues and hardware thread wrappers. Each requester raises a request line and presents a message of three fields: a destination address, a 3-bit operation code and a 32-bit data word. At every clock edge the arbiter picks at most one winner. In the following cycle it drives that winner's message onto the shared bus outputs, together with a one-hot grant and a bus-valid flag.

The winner is chosen by a three-tier policy. The processor-interface requester always wins when it is competing. Otherwise, a requester whose message is addressed to the processor wins. Otherwise, the requester that has waited the most cycles wins. Each requester has a saturating wait counter. Ties go to the lowest requester index. A requester holds its request and message stable until it sees its grant. It may then drop the request or present a new message.

A two-state machine tracks the bus. `ST_IDLE` means no message is on the bus in this cycle. `ST_GRANT` means a granted message is on the bus. The transition `IDLE->GRANT` or `GRANT->GRANT` is taken at an edge where at least one requester is eligible. The transition `GRANT->IDLE` or `IDLE->IDLE` is taken at an edge where no requester is eligible.

Top module: `msg_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all grants are low, bus-valid is low and the bus address, operation and data are zero.
- R2: A requester that is eligible alone at an edge has its grant and its message on the bus in the cycle that begins at that edge, which is one cycle of latency.
- R3: At most one grant bit is high in any cycle, and bus-valid is high exactly when a grant bit is high.
- R4: While bus-valid is high, the bus address, operation and data equal the fields that the granted requester presented at the deciding edge. While bus-valid is low, all three are zero.
- R5: The processor-interface requester (index CPU_IDX, default 0) wins every edge at which it is eligible.
- R6: If the processor-interface requester is not eligible, a requester whose destination equals CPU_ADDR (default 0) wins. Among several such requesters, the one with the larger wait count wins, and on equal counts the lower index wins.
- R7: If no eligible requester is addressed to the processor, the one with the largest wait count wins, and on equal counts the lower index wins.
- R8: A requester's wait count rises by one at each edge where it is eligible and not chosen. It saturates at 2^AGE_W-1. It clears when the requester is chosen or is not eligible.
- R9: A requester is eligible at an edge when its request is high and its grant is low in the cycle before that edge. A requester that keeps its request high across its grant is not chosen again at the edge that closes its grant cycle.
- R10: Operation codes are carried on the bus unchanged. The defined codes are give=0, take=1, start=2, stop=3 and ack=4. The reserved codes 5 to 7 pass through like any other code.
- R11: While any requester is eligible at every edge, bus-valid stays high in every cycle, which gives one message per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_REQ | Request line per requester |
| dst_i | input | N_REQ*ADDR_W | Destination address per requester, requester i at bits [i*ADDR_W +: ADDR_W] |
| op_i | input | N_REQ*3 | Operation code per requester, requester i at bits [i*3 +: 3] |
| data_i | input | N_REQ*32 | Data word per requester, requester i at bits [i*32 +: 32] |
| gnt_o | output | N_REQ | One-hot grant for the message on the bus this cycle |
| bus_vld_o | output | 1 | High when the bus carries a granted message |
| bus_dst_o | output | ADDR_W | Bus destination address |
| bus_op_o | output | 3 | Bus operation code |
| bus_data_o | output | 32 | Bus data word |

## Verification
The bench aims at the edge right after a grant. A design that ignored the grant mask would hand the same held message out twice. A starvation scenario drives two requesters to the saturated wait count. There, a counter that wraps or keeps counting would let the older, higher-index requester win the tie, or would pick a requester at random. Directed cases set the processor tier against the address tier, and the address tier against an older requester. These cases catch a design that orders the tiers wrongly or breaks ties towards the higher index. A long random phase with reserved operation codes also catches a mux that shifts or drops message fields.

// File: rtl/msg_arb_pkg.sv
package msg_arb_pkg;

    localparam int OP_W   = 3;
    localparam int DATA_W = 32;

    // Operation codes carried on the bus (R10); 5..7 are reserved.
    typedef enum logic [OP_W-1:0] {
        OP_GIVE  = 3'd0,
        OP_TAKE  = 3'd1,
        OP_START = 3'd2,
        OP_STOP  = 3'd3,
        OP_ACK   = 3'd4
    } bus_op_e;

    // Bus occupancy state.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } bus_state_e;

endpackage

// File: rtl/msg_arb_age.sv
module msg_arb_age #(
    parameter int AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_i,
    input  logic             win_i,
    output logic [AGE_W-1:0] age_o
);

    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    // Wait counter: counts edges spent eligible but not chosen (R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_o <= '0;
        end else if (!pend_i || win_i) begin
            age_o <= '0;
        end else if (age_o != AGE_MAX) begin
            age_o <= age_o + 1'b1;
        end
    end

endmodule

// File: rtl/msg_arb_pick.sv
module msg_arb_pick #(
    parameter int N_REQ    = 6,
    parameter int ADDR_W   = 3,
    parameter int AGE_W    = 4,
    parameter int CPU_IDX  = 0,
    parameter int CPU_ADDR = 0,
    parameter int IDX_W    = 3
) (
    input  logic [N_REQ-1:0]        elig_i,
    input  logic [N_REQ*ADDR_W-1:0] dst_i,
    input  logic [N_REQ*AGE_W-1:0]  age_i,
    output logic                    any_o,
    output logic [IDX_W-1:0]        win_idx_o,
    output logic [N_REQ-1:0]        win_oh_o
);

    localparam logic [ADDR_W-1:0] CPU_A = ADDR_W'(CPU_ADDR);

    // Ranking key: address tier above wait count.
    logic [AGE_W:0] key [N_REQ];

    for (genvar g = 0; g < N_REQ; g++) begin : g_key
        assign key[g] = {dst_i[g*ADDR_W +: ADDR_W] == CPU_A, age_i[g*AGE_W +: AGE_W]};
    end

    logic           found;
    logic [AGE_W:0] best_key;
    logic [IDX_W-1:0] best;

    always_comb begin
        found    = 1'b0;
        best_key = '0;
        best     = '0;
        // Ascending scan with strict compare keeps the lowest index on ties.
        for (int i = 0; i < N_REQ; i++) begin
            if (elig_i[i] && (!found || key[i] > best_key)) begin
                found    = 1'b1;
                best_key = key[i];
                best     = IDX_W'(i);
            end
        end
        // Processor tier overrides everything.
        if (elig_i[CPU_IDX]) begin
            best = IDX_W'(CPU_IDX);
        end
    end

    always_comb begin
        win_oh_o = '0;
        if (found) begin
            win_oh_o[best] = 1'b1;
        end
    end

    assign any_o     = found;
    assign win_idx_o = best;

endmodule

// File: rtl/msg_arb.sv
module msg_arb
    import msg_arb_pkg::*;
#(
    parameter int N_REQ    = 6,
    parameter int ADDR_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    parameter int AGE_W    = 4,
    parameter int CPU_IDX  = 0,
    parameter int CPU_ADDR = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REQ-1:0]        req_i,
    input  logic [N_REQ*ADDR_W-1:0] dst_i,
    input  logic [N_REQ*OP_W-1:0]   op_i,
    input  logic [N_REQ*DATA_W-1:0] data_i,
    output logic [N_REQ-1:0]        gnt_o,
    output logic                    bus_vld_o,
    output logic [ADDR_W-1:0]       bus_dst_o,
    output logic [OP_W-1:0]         bus_op_o,
    output logic [DATA_W-1:0]       bus_data_o
);

    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    bus_state_e state_q, state_d;

    logic [N_REQ-1:0]       gnt_q;
    logic [N_REQ-1:0]       elig;
    logic [N_REQ*AGE_W-1:0] ages;
    logic                   any_win;
    logic [IDX_W-1:0]       win_idx;
    logic [N_REQ-1:0]       win_oh;
    logic [ADDR_W-1:0]      dst_q;
    logic [OP_W-1:0]        op_q;
    logic [DATA_W-1:0]      data_q;

    // A request whose grant is showing this cycle is treated as consumed.
    assign elig = req_i & ~gnt_q;

    for (genvar g = 0; g < N_REQ; g++) begin : g_age
        msg_arb_age #(
            .AGE_W (AGE_W)
        ) u_age (
            .clk    (clk),
            .rst_n  (rst_n),
            .pend_i (elig[g]),
            .win_i  (win_oh[g]),
            .age_o  (ages[g*AGE_W +: AGE_W])
        );
    end

    msg_arb_pick #(
        .N_REQ    (N_REQ),
        .ADDR_W   (ADDR_W),
        .AGE_W    (AGE_W),
        .CPU_IDX  (CPU_IDX),
        .CPU_ADDR (CPU_ADDR),
        .IDX_W    (IDX_W)
    ) u_pick (
        .elig_i    (elig),
        .dst_i     (dst_i),
        .age_i     (ages),
        .any_o     (any_win),
        .win_idx_o (win_idx),
        .win_oh_o  (win_oh)
    );

    // Next-state logic.
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = any_win ? ST_GRANT : ST_IDLE;
            ST_GRANT: state_d = any_win ? ST_GRANT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: grant and message of the winner, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            dst_q  <= '0;
            op_q   <= '0;
            data_q <= '0;
        end else if (any_win) begin
            gnt_q  <= win_oh;
            dst_q  <= dst_i[win_idx*ADDR_W +: ADDR_W];
            op_q   <= op_i[win_idx*OP_W +: OP_W];
            data_q <= data_i[win_idx*DATA_W +: DATA_W];
        end else begin
            gnt_q  <= '0;
            dst_q  <= '0;
            op_q   <= '0;
            data_q <= '0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_GRANT: bus_vld_o = 1'b1;
            default:  bus_vld_o = 1'b0;
        endcase
    end

    assign gnt_o      = gnt_q;
    assign bus_dst_o  = dst_q;
    assign bus_op_o   = op_q;
    assign bus_data_o = data_q;

endmodule

// File: rtl/msg_arb_chk.sv
module msg_arb_chk #(
    parameter int N_REQ   = 6,
    parameter int ADDR_W  = 3,
    parameter int CPU_IDX = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_REQ-1:0]  req_i,
    input logic [N_REQ-1:0]  gnt_o,
    input logic              bus_vld_o,
    input logic [ADDR_W-1:0] bus_dst_o,
    input logic [2:0]        bus_op_o,
    input logic [31:0]       bus_data_o
);

    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    p_vld_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_vld_o == (gnt_o != '0));

    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_vld_o |-> (bus_dst_o == '0 && bus_op_o == '0 && bus_data_o == '0));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & ~gnt_o) != '0) |=> bus_vld_o);

    p_cpu_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i[CPU_IDX] && !gnt_o[CPU_IDX]) |=> gnt_o[CPU_IDX]);

    p_grant_eligible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> ((gnt_o & ~$past(req_i & ~gnt_o)) == '0));

endmodule

bind msg_arb msg_arb_chk #(
    .N_REQ   (N_REQ),
    .ADDR_W  (ADDR_W),
    .CPU_IDX (CPU_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .gnt_o      (gnt_o),
    .bus_vld_o  (bus_vld_o),
    .bus_dst_o  (bus_dst_o),
    .bus_op_o   (bus_op_o),
    .bus_data_o (bus_data_o)
);

// File: tb/test_msg_arb.sv
module test_msg_arb;

    localparam int N  = 6;
    localparam int AW = 3;
    localparam int SAT = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]    req = '0;
    logic [AW-1:0]   dst  [N];
    logic [2:0]      op   [N];
    logic [31:0]     data [N];
    logic [N*AW-1:0] dst_v;
    logic [N*3-1:0]  op_v;
    logic [N*32-1:0] data_v;

    logic [N-1:0]  gnt;
    logic          vld;
    logic [AW-1:0] b_dst;
    logic [2:0]    b_op;
    logic [31:0]   b_data;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            dst_v[i*AW +: AW] = dst[i];
            op_v[i*3 +: 3]    = op[i];
            data_v[i*32 +: 32] = data[i];
        end
    end

    msg_arb i_msg_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .dst_i      (dst_v),
        .op_i       (op_v),
        .data_i     (data_v),
        .gnt_o      (gnt),
        .bus_vld_o  (vld),
        .bus_dst_o  (b_dst),
        .bus_op_o   (b_op),
        .bus_data_o (b_data)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Reference model state.
    int            mage [N];
    logic [N-1:0]  e_gnt = '0;
    logic          e_vld = 1'b0;
    logic [AW-1:0] e_dst = '0;
    logic [2:0]    e_op  = '0;
    logic [31:0]   e_data = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Winner from the requirements: processor tier, address tier, then age, lowest index.
    function automatic int pick(input logic [N-1:0] el);
        int best = -1;
        int bk = -1;
        for (int i = 0; i < N; i++) begin
            if (el[i]) begin
                int k = (dst[i] == '0 ? 100 : 0) + mage[i];
                if (best < 0 || k > bk) begin
                    best = i;
                    bk = k;
                end
            end
        end
        if (el[0]) best = 0;
        return best;
    endfunction

    task automatic model_step();
        logic [N-1:0] el = req & ~e_gnt;
        int w = pick(el);
        for (int i = 0; i < N; i++) begin
            if (!el[i] || i == w) mage[i] = 0;
            else if (mage[i] < SAT) mage[i] = mage[i] + 1;
        end
        if (w >= 0) begin
            e_gnt = '0;
            e_gnt[w] = 1'b1;
            e_vld = 1'b1;
            e_dst = dst[w];
            e_op = op[w];
            e_data = data[w];
        end else begin
            e_gnt = '0;
            e_vld = 1'b0;
            e_dst = '0;
            e_op = '0;
            e_data = '0;
        end
    endtask

    task automatic compare();
        chk("R7 grant vector", 64'(gnt), 64'(e_gnt));
        chk("R3 bus valid", 64'(vld), 64'(e_vld));
        chk("R4 bus message", {29'd0, b_dst, b_op, b_data}, {29'd0, e_dst, e_op, e_data});
    endtask

    // Called at a negedge with inputs settled: advance one edge and compare.
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic set_msg(input int i, input logic [AW-1:0] d, input logic [2:0] o, input logic [31:0] v);
        req[i] = 1'b1;
        dst[i] = d;
        op[i] = o;
        data[i] = v;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            dst[i] = '0;
            op[i] = '0;
            data[i] = '0;
            mage[i] = 0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 grant in reset", 64'(gnt), 64'd0);
        chk("R1 valid in reset", 64'(vld), 64'd0);
        chk("R1 message in reset", {29'd0, b_dst, b_op, b_data}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {gnt, vld, b_data}, 64'd0);

        // R2 and R10: lone request with a reserved op code
        set_msg(3, 3'd5, 3'd6, 32'hCAFE_0003);
        cycle();
        chk("R2 lone grant", 64'(gnt), 64'h8);
        chk("R10 reserved op passes", 64'(b_op), 64'd6);
        // R9: held request is not granted again at the next edge
        cycle();
        chk("R9 no regrant", {gnt, vld}, 64'd0);
        cycle();
        chk("R9 regrant after gap", 64'(gnt), 64'h8);
        req[3] = 1'b0;
        cycle();

        // R5, R6, R7, R11: all raise together; 4 targets the processor
        set_msg(0, 3'd2, 3'd4, 32'h0000_0A00);
        set_msg(1, 3'd3, 3'd0, 32'h0000_0A01);
        set_msg(2, 3'd4, 3'd1, 32'h0000_0A02);
        set_msg(3, 3'd5, 3'd2, 32'h0000_0A03);
        set_msg(4, 3'd0, 3'd3, 32'h0000_0A04);
        set_msg(5, 3'd1, 3'd7, 32'h0000_0A05);
        cycle();
        chk("R5 processor first", 64'(gnt), 64'h01);
        req[0] = 1'b0;
        cycle();
        chk("R6 addressed to processor next", 64'(gnt), 64'h10);
        req[4] = 1'b0;
        cycle();
        chk("R7 tie to lowest index", 64'(gnt), 64'h02);
        chk("R11 valid every cycle", 64'(vld), 64'd1);
        req = '0;
        cycle();
        cycle();

        // R7: older higher index beats younger lower index
        set_msg(1, 3'd0, 3'd0, 32'h11);
        set_msg(5, 3'd3, 3'd1, 32'h55);
        cycle();
        chk("R6 addressed requester wins", 64'(gnt), 64'h02);
        req[1] = 1'b0;
        set_msg(2, 3'd3, 3'd2, 32'h22);
        cycle();
        chk("R7 older wins", 64'(gnt), 64'h20);
        req = '0;
        cycle();
        cycle();

        // R8: saturation; 4 starts waiting before 3, both saturate, lower index wins
        set_msg(0, 3'd1, 3'd0, 32'h100);
        set_msg(1, 3'd0, 3'd0, 32'h101);
        set_msg(2, 3'd0, 3'd0, 32'h102);
        set_msg(4, 3'd5, 3'd3, 32'h104);
        for (int c = 0; c < 45; c++) begin
            if (c == 5) set_msg(3, 3'd5, 3'd3, 32'h103);
            cycle();
            chk("R8 starved requesters wait", 64'(gnt[4:3]), 64'd0);
        end
        req[0] = 1'b0;
        req[1] = 1'b0;
        req[2] = 1'b0;
        cycle();
        chk("R8 saturated tie to lowest index", 64'(gnt), 64'h08);
        req[3] = 1'b0;
        cycle();
        chk("R8 remaining requester", 64'(gnt), 64'h10);
        req = '0;
        cycle();
        cycle();

        // Random phase checked against the model (R3, R4, R5, R6, R7, R8, R9).
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < N; i++) begin
                if (req[i] && e_gnt[i]) begin
                    if ($urandom_range(1, 0) == 1) begin
                        set_msg(i, ($urandom_range(3, 0) == 0) ? 3'd0 : 3'($urandom_range(5, 1)),
                                3'($urandom_range(7, 0)), $urandom());
                    end else begin
                        req[i] = 1'b0;
                    end
                end else if (!req[i] && $urandom_range(99, 0) < ((i == 0) ? 10 : 35)) begin
                    set_msg(i, ($urandom_range(3, 0) == 0) ? 3'd0 : 3'($urandom_range(5, 1)),
                            3'($urandom_range(7, 0)), $urandom());
                end
            end
            cycle();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule